// File: doc/BRIEF.md
# Data Access Protection Checker

This block decides whether a data-side memory access, or a cache-management operation, must raise a data storage fault. It applies a two-level zone protection scheme. A 2-bit zone code, chosen for the page by the surrounding MMU, overrides the page's write-enable bit, and it does so differently in user mode and in supervisor mode. A store to a page marked with a user-defined attribute can also fault, whatever the privilege, when that attribute's exception enable is set.

Cache-management operations follow rules of their own. Touch hints turn into no-ops where a real access would fault. Data-cache invalidates are treated as stores. Instruction-cache operations are checked as loads of the addressed byte. Their operand translation follows the data-translation enable. The privileged cache operations never raise a zone fault in user mode; they raise the privileged-instruction flag instead.

One request is presented on `in_*` with `in_valid` high. The verdict appears on `out_*` with `out_valid` high on the following clock edge. There is no back-pressure. The checker accepts a request on every cycle, and the consumer must take each result in the cycle it is shown. Verdict outputs keep their last value while `out_valid` is low. TLB lookup, address translation and the interrupt sequence itself belong to neighbouring blocks.

Top module: `dap_checker`

## Requirements
- R1: A request sampled with `in_valid` high produces `out_valid` high exactly one cycle later. A cycle with `in_valid` low produces `out_valid` low one cycle later.
- R2: While `rst_n` is low, `out_valid`, `out_fault`, `out_cause`, `out_nop` and `out_priv` are all 0.
- R3: A store-class operation (store 1, block zero 4, data invalidate 7, data congruence invalidate 8) to a page with `in_uattr`=1 and `in_uattr_xe`=1 faults with cause 4. This holds in either privilege state and with translation on or off, unless a higher rule fires or the privileged flag is raised.
- R4: In user mode with translation on and zone 00, these operations fault: load 0, store 1, block zero 4, block store 5, block flush 6, instruction invalidate 9, and reserved codes 12 to 15. The cause is 2 for store 1 and block zero 4, and 1 for all the others.
- R5: In user mode with translation on and zone 00, data touch 2 and touch-for-store 3 give `out_nop`=1 and no fault. `out_nop` is 0 in every other case.
- R6: In user mode, operations 7, 8, 10 and 11 give `out_priv`=1 and never fault, whatever the zone and translation state. In supervisor mode `out_priv` is 0.
- R7: In user mode with translation on, a store 1 or block zero 4 to a page with `in_wr_en`=0 and zone 01 or 10 faults with cause 3. Zone 11 grants the write.
- R8: In supervisor mode with translation on, a store 1, block zero 4, data invalidate 7 or data congruence invalidate 8 to a page with `in_wr_en`=0 faults with cause 3 when the zone is 00 or 01. Zones 10 and 11 grant the write.
- R9: Instruction-cache operations 9, 10 and 11 are checked as loads. They never fault with cause 2, 3 or 4.
- R10: With `in_xlate`=0, the only fault that can occur is cause 4.
- R11: Cause codes are 0 none, 1 zone fault on a load, 2 zone fault on a store, 3 write protection, 4 user attribute. The priority is zone over write protection over user attribute. `out_fault` is 1 exactly when the cause is nonzero.
- R12: Operation codes on `in_op`: 0 load, 1 store, 2 data touch, 3 data touch-for-store, 4 block zero, 5 block store, 6 block flush, 7 data invalidate, 8 data congruence invalidate, 9 instruction invalidate, 10 instruction touch, 11 instruction congruence invalidate. Codes 12 to 15 are treated as loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 4 | Operation code (R12) |
| in_supervisor | input | 1 | 1 = supervisor state, 0 = user state |
| in_xlate | input | 1 | Data-translation enable |
| in_wr_en | input | 1 | Page write-enable bit |
| in_uattr | input | 1 | Page user-defined attribute bit |
| in_uattr_xe | input | 1 | Exception enable for the user-defined attribute |
| in_zone | input | 2 | Zone protection code selected for the page |
| out_valid | output | 1 | Verdict strobe, one cycle after `in_valid` |
| out_fault | output | 1 | Data storage fault |
| out_cause | output | 3 | Fault cause code (R11) |
| out_nop | output | 1 | Touch hint completes as a no-op |
| out_priv | output | 1 | Privileged operation attempted in user mode |

## Verification
The assertions assume the request fields are stable and known on every edge where `in_valid` is high. They also assume the consumer never needs to stall, since the block offers no way to hold a result. The stimulus drives every field from the falling clock edge and keeps `in_valid` as a clean strobe. It walks every combination of operation code, privilege, translation, write enable, attribute, attribute enable and zone, and it inserts idle cycles so that the low-strobe path is exercised as well. Reserved operation codes are included in the walk, because the requirements define their handling.

// File: rtl/dap_pkg.sv
package dap_pkg;
  localparam int OP_W    = 4;
  localparam int ZONE_W  = 2;
  localparam int CAUSE_W = 3;

  localparam logic [ZONE_W-1:0] ZONE_DENY = 2'b00;
  localparam logic [ZONE_W-1:0] ZONE_SUPW = 2'b10;
  localparam logic [ZONE_W-1:0] ZONE_FULL = 2'b11;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD     = 4'd0,
    OP_STORE    = 4'd1,
    OP_DTOUCH   = 4'd2,
    OP_DTOUCHST = 4'd3,
    OP_DZERO    = 4'd4,
    OP_DSTBLK   = 4'd5,
    OP_DFLUSH   = 4'd6,
    OP_DINV     = 4'd7,
    OP_DCINV    = 4'd8,
    OP_IINV     = 4'd9,
    OP_ITOUCH   = 4'd10,
    OP_ICINV    = 4'd11
  } op_e;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_ZONE_LD = 3'd1,
    CAUSE_ZONE_ST = 3'd2,
    CAUSE_WPROT   = 3'd3,
    CAUSE_UATTR   = 3'd4
  } cause_e;

  // Protection class of one operation code
  typedef struct packed {
    logic zone_ld;   // zone-faults as a load in user mode
    logic zone_st;   // zone-faults as a store in user mode
    logic user_wr;   // write-checked in user mode
    logic sup_wr;    // write-checked in supervisor mode
    logic attr_st;   // subject to the user-attribute store fault
    logic touch;     // touch hint
    logic priv;      // privileged operation
  } op_traits_t;

  typedef struct packed {
    logic                fault;
    logic [CAUSE_W-1:0]  cause;
    logic                nop;
    logic                priv;
  } verdict_t;
endpackage

// File: rtl/dap_op_decode.sv
module dap_op_decode
  import dap_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output op_traits_t      traits
);
  always_comb begin
    traits = '0;
    case (op)
      OP_LOAD, OP_DSTBLK, OP_DFLUSH, OP_IINV: traits.zone_ld = 1'b1;
      OP_STORE, OP_DZERO: begin
        traits.zone_st = 1'b1;
        traits.user_wr = 1'b1;
        traits.sup_wr  = 1'b1;
        traits.attr_st = 1'b1;
      end
      OP_DTOUCH, OP_DTOUCHST: traits.touch = 1'b1;
      OP_DINV, OP_DCINV: begin
        traits.priv    = 1'b1;
        traits.sup_wr  = 1'b1;
        traits.attr_st = 1'b1;
      end
      OP_ITOUCH, OP_ICINV: traits.priv = 1'b1;
      default: traits.zone_ld = 1'b1;  // reserved codes behave as loads
    endcase
  end
endmodule

// File: rtl/dap_rule_eval.sv
module dap_rule_eval
  import dap_pkg::*;
(
  input  op_traits_t        traits,
  input  logic              supervisor,
  input  logic              xlate,
  input  logic              wr_en,
  input  logic              uattr,
  input  logic              uattr_xe,
  input  logic [ZONE_W-1:0] zone,
  output verdict_t          verdict
);
  logic user_priv, zone_hit, wp_user, wp_sup, wp_hit, attr_hit, touch_nop;

  always_comb begin
    user_priv = !supervisor && traits.priv;
    zone_hit  = !supervisor && xlate && (zone == ZONE_DENY) &&
                (traits.zone_ld || traits.zone_st);
    wp_user   = !supervisor && traits.user_wr && (zone != ZONE_FULL);
    wp_sup    = supervisor && traits.sup_wr &&
                (zone != ZONE_FULL) && (zone != ZONE_SUPW);
    wp_hit    = xlate && !wr_en && (wp_user || wp_sup);
    attr_hit  = traits.attr_st && uattr && uattr_xe;
    touch_nop = !supervisor && xlate && (zone == ZONE_DENY) && traits.touch;

    verdict       = '0;
    verdict.priv  = user_priv;
    verdict.nop   = touch_nop;
    if (!user_priv) begin
      if (zone_hit) begin
        verdict.fault = 1'b1;
        verdict.cause = traits.zone_st ? CAUSE_ZONE_ST : CAUSE_ZONE_LD;
      end else if (wp_hit) begin
        verdict.fault = 1'b1;
        verdict.cause = CAUSE_WPROT;
      end else if (attr_hit) begin
        verdict.fault = 1'b1;
        verdict.cause = CAUSE_UATTR;
      end
    end
  end
endmodule

// File: rtl/dap_result_reg.sv
module dap_result_reg
  import dap_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  verdict_t d,
  output logic     q_valid,
  output verdict_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= load;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/dap_checker.sv
module dap_checker
  import dap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [OP_W-1:0]    in_op,
  input  logic               in_supervisor,
  input  logic               in_xlate,
  input  logic               in_wr_en,
  input  logic               in_uattr,
  input  logic               in_uattr_xe,
  input  logic [ZONE_W-1:0]  in_zone,
  output logic               out_valid,
  output logic               out_fault,
  output logic [CAUSE_W-1:0] out_cause,
  output logic               out_nop,
  output logic               out_priv
);
  op_traits_t traits;
  verdict_t   comb_v, reg_v;

  dap_op_decode u_dec (.op(in_op), .traits(traits));

  dap_rule_eval u_eval (
    .traits(traits), .supervisor(in_supervisor), .xlate(in_xlate),
    .wr_en(in_wr_en), .uattr(in_uattr), .uattr_xe(in_uattr_xe),
    .zone(in_zone), .verdict(comb_v)
  );

  dap_result_reg u_reg (
    .clk(clk), .rst_n(rst_n), .load(in_valid), .d(comb_v),
    .q_valid(out_valid), .q(reg_v)
  );

  assign out_fault = reg_v.fault;
  assign out_cause = reg_v.cause;
  assign out_nop   = reg_v.nop;
  assign out_priv  = reg_v.priv;
endmodule

// File: rtl/dap_checker_sva.sv
module dap_checker_sva
  import dap_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_supervisor,
  input logic               in_xlate,
  input logic [ZONE_W-1:0]  in_zone,
  input logic               out_valid,
  input logic               out_fault,
  input logic [CAUSE_W-1:0] out_cause,
  input logic               out_nop,
  input logic               out_priv
);
  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R1
  AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R1
  AST_FAULT_MATCHES_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_fault == (out_cause != CAUSE_NONE)));  // R11
  AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cause <= CAUSE_UATTR));  // R11
  AST_PRIV_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_priv) |-> !out_fault);  // R6
  AST_NOP_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_nop) |-> !out_fault);  // R5
  AST_SUP_NO_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_supervisor) |=> !out_priv);  // R6
  AST_NOXLATE_ATTR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_xlate) |=> (out_cause == CAUSE_NONE || out_cause == CAUSE_UATTR));  // R10
  AST_FULL_ZONE_NO_WPROT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_zone == ZONE_FULL) |=> (out_cause != CAUSE_WPROT));  // R7
  AST_SUP_NO_ZONE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_supervisor) |=> (out_cause != CAUSE_ZONE_LD && out_cause != CAUSE_ZONE_ST));  // R4
endmodule

bind dap_checker dap_checker_sva u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .in_supervisor(in_supervisor), .in_xlate(in_xlate), .in_zone(in_zone),
  .out_valid(out_valid), .out_fault(out_fault), .out_cause(out_cause),
  .out_nop(out_nop), .out_priv(out_priv)
);

// File: tb/sim_dap_checker.sv
`timescale 1ns/1ps
module sim_dap_checker;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic       rst_n, in_valid, in_supervisor, in_xlate, in_wr_en, in_uattr, in_uattr_xe;
  logic [3:0] in_op;
  logic [1:0] in_zone;
  logic       out_valid, out_fault, out_nop, out_priv;
  logic [2:0] out_cause;

  dap_checker u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_supervisor(in_supervisor), .in_xlate(in_xlate), .in_wr_en(in_wr_en),
    .in_uattr(in_uattr), .in_uattr_xe(in_uattr_xe), .in_zone(in_zone),
    .out_valid(out_valid), .out_fault(out_fault), .out_cause(out_cause),
    .out_nop(out_nop), .out_priv(out_priv)
  );

  typedef struct {
    bit       fault;
    bit [2:0] cause;
    bit       nop;
    bit       priv;
    string    tag;
  } exp_t;

  exp_t q[$];
  int   tests = 0, fails = 0;
  bit   exp_v = 1'b0;
  bit   done = 1'b0;

  function automatic exp_t model(int op, bit sup, bit xl, bit wr, bit ua, bit uxe, int zone);
    exp_t e;
    bit is_priv  = (op == 7 || op == 8 || op == 10 || op == 11);
    bit zone_op  = (op == 0 || op == 1 || op == 4 || op == 5 || op == 6 || op == 9 || op >= 12);
    bit st_zone  = (op == 1 || op == 4);
    bit st_class = (op == 1 || op == 4 || op == 7 || op == 8);
    e.fault = 0; e.cause = 0; e.nop = 0; e.priv = 0;
    e.tag = (op >= 9 && op <= 11) ? "R9" : (!xl ? "R10" : "R11");
    if (!sup && is_priv) begin
      e.priv = 1; e.tag = "R6";                                    // R6
      return e;
    end
    if (!sup && xl && zone == 0 && (op == 2 || op == 3)) begin
      e.nop = 1; e.tag = "R5";                                     // R5
      return e;
    end
    if (!sup && xl && zone == 0 && zone_op) begin
      e.fault = 1; e.cause = st_zone ? 3'd2 : 3'd1; e.tag = "R4";  // R4
    end else if (xl && !wr && !sup && st_zone && zone != 3) begin
      e.fault = 1; e.cause = 3'd3; e.tag = "R7";                   // R7
    end else if (xl && !wr && sup && st_class && (zone == 0 || zone == 1)) begin
      e.fault = 1; e.cause = 3'd3; e.tag = "R8";                   // R8
    end else if (st_class && ua && uxe) begin
      e.fault = 1; e.cause = 3'd4; e.tag = "R3";                   // R3
    end
    return e;
  endfunction

  // Driver: op codes per R12
  task automatic drive(int op, bit sup, bit xl, bit wr, bit ua, bit uxe, int zone);
    @(negedge clk);
    in_valid = 1; in_op = op[3:0]; in_supervisor = sup; in_xlate = xl;
    in_wr_en = wr; in_uattr = ua; in_uattr_xe = uxe; in_zone = zone[1:0];
    q.push_back(model(op, sup, xl, wr, ua, uxe, zone));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
    in_op = 4'hf; in_supervisor = 0; in_xlate = 1; in_wr_en = 0; in_zone = 0;
    in_uattr = 1; in_uattr_xe = 1;
  endtask

  always @(posedge clk) exp_v <= rst_n && in_valid;

  // Monitor: compare against the scoreboard on the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      tests++;
      if (out_valid !== exp_v) begin
        fails++;
        $display("FAIL R1 out_valid actual=%0b expected=%0b", out_valid, exp_v);
      end
      if (out_valid === 1'b1 && exp_v) begin
        exp_t e;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R1 result actual=present expected=none");
        end else begin
          e = q.pop_front();
          tests++;
          if (out_fault !== e.fault || out_cause !== e.cause ||
              out_nop !== e.nop || out_priv !== e.priv) begin
            fails++;
            $display("FAIL %s f/c/n/p actual=%0b/%0d/%0b/%0b expected=%0b/%0d/%0b/%0b",
                     e.tag, out_fault, out_cause, out_nop, out_priv,
                     e.fault, e.cause, e.nop, e.priv);
          end
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0; in_valid = 0; in_op = 0; in_supervisor = 0; in_xlate = 0;
    in_wr_en = 0; in_uattr = 0; in_uattr_xe = 0; in_zone = 0;
    repeat (3) @(negedge clk);
    tests++;  // R2 reset state
    if ({out_valid, out_fault, out_cause, out_nop, out_priv} !== 7'b0) begin
      fails++;
      $display("FAIL R2 outputs actual=%b expected=0000000",
               {out_valid, out_fault, out_cause, out_nop, out_priv});
    end
    rst_n = 1;
    for (int op = 0; op < 16; op++) begin
      for (int v = 0; v < 128; v++) begin
        drive(op, v[0], v[1], v[2], v[3], v[4], v[6:5]);
        if (v % 11 == 10) idle();  // R1 quiet cycles between requests
      end
    end
    idle();
    repeat (4) @(negedge clk);
    tests++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R1 pending actual=%0d expected=0", q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule